// File: doc/BRIEF.md
# Dual-Role SPI Byte Port

This block is one SPI serial port whose role is set by a 4-bit mode code in its control register. As bus master it produces the serial clock from the system clock and starts one byte exchange each time the host writes the data buffer. As bus slave it follows a clock from outside and answers with whatever byte the host last loaded. In both roles the exchange is full duplex: one byte leaves on SDO, most significant bit first, while one byte arrives on SDI. Either byte may carry no meaning for the application.

The host reaches the port through a small register interface. A control write sets the enable, the clock polarity and the mode. A buffer write loads the byte to send, and a buffer read clears the "byte received" flag. While the enable bit is clear, the whole engine is held in reset. The engine always samples data on the clock as seen at its input pin. Because of this, a master must have its SCK output looped back to `sck_i`. The three inputs SCK, SDI and SS each pass through a two-flop synchronizer before any edge is detected.

Top module: `spi_port`

## Requirements
- R1: Control bit 5 is the enable. While it is 0, `sck_oe`, `sdo_oe`, `buf_full` and `wcol` are 0 and SCK rests at its idle level. Clearing it in the middle of a transfer aborts the transfer, so no byte is delivered.
- R2: Mode bits 3:0 select the role. Codes 00xx select master. 0100 selects slave with SS in use, and 0101 selects slave with SS ignored. Any other code leaves the port inactive, so a buffer write produces no SCK edges and no output enables.
- R3: In master mode a buffer write starts a transfer. SCK then makes exactly 16 level changes, one every HALF_BASE·4^mode[1:0] system cycles.
- R4: Control bit 4 is the clock polarity. A master's SCK rests at that level before and after every transfer.
- R5: Bytes move MSb first, full duplex. When SDO is looped back to SDI, the master receives the byte it sent. A constant SDI of 1 gives 0xFF and a constant SDI of 0 gives 0x00.
- R6: A bit is sampled on the SCK edge leaving the idle level and shifted out on the edge returning to it. A slave presents bit 7 of the loaded byte on SDO before the first clock edge.
- R7: `buf_full` rises when a received byte is copied into the buffer. That byte is then visible on `buf_rdata`. A `buf_rd` pulse clears `buf_full`.
- R8: A buffer write while a transfer is in progress is ignored and sets `wcol`. The byte being exchanged is unchanged. Any control write clears `wcol`.
- R9: In slave-with-SS mode, while `ss_n` is high, `sdo_oe` is 0, clock edges are ignored and the bit count returns to zero. A partial byte cut short by SS is discarded.
- R10: In master mode data is sampled on `sck_i`. If `sck_i` stays at its idle level, SCK still toggles but no byte is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control value: bit 5 enable, bit 4 polarity, bits 3:0 mode |
| buf_wr | input | 1 | Buffer write strobe (loads transmit byte, starts master transfer) |
| buf_wdata | input | DATA_W | Byte to transmit |
| buf_rd | input | 1 | Buffer read strobe, clears `buf_full` |
| buf_rdata | output | DATA_W | Buffer contents |
| buf_full | output | 1 | Received byte waiting |
| wcol | output | 1 | Write-collision flag |
| sck_i | input | 1 | Serial clock as seen at the pin |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | SCK output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |
| ss_n | input | 1 | Slave select, active low |

## Verification
Each register on the path sets the delay before a result appears. A change on `sck_i`, `sdi` or `ss_n` takes two synchronizer stages and one edge register, so its effect is seen on the third clock edge after it. A received byte therefore reaches `buf_full` and `buf_rdata` about three cycles after the sampling edge at the pin. Control and buffer strobes affect the flags and output enables one edge after they are applied. The bench drives at falling edges. For every strobe it samples one cycle later. For whole transfers it waits a margin well past the sixteenth SCK change, or more than eight cycles per bench-driven SCK phase, before reading results.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {ROLE_OFF, ROLE_MASTER, ROLE_SLAVE} role_e;

  // Control layout: bit 5 enable, bit 4 clock polarity, bits 3:0 mode code
  typedef struct packed {
    logic       en;
    logic       cpol;
    logic [3:0] mode;
  } ctrl_t;

  function automatic role_e decode_role(input logic [3:0] m);
    if (m[3:2] == 2'b00)       return ROLE_MASTER;
    else if (m[3:1] == 3'b010) return ROLE_SLAVE;
    else                       return ROLE_OFF;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g+1] <= INIT;
      else     chain[g+1] <= chain[g];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int HALF_BASE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cpol,
  input  logic [1:0] div_sel,
  output logic       sck_q,
  output logic       run
);
  localparam int MAXHALF = HALF_BASE << 6;
  localparam int DIVW    = $clog2(MAXHALF + 1);

  logic [DIVW-1:0] div_cnt;
  logic [DIVW-1:0] half_m1;
  logic [3:0]      tgl_cnt;

  always_comb half_m1 = DIVW'((HALF_BASE << (2 * div_sel)) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      div_cnt <= '0;
      tgl_cnt <= '0;
      sck_q   <= cpol;
    end else if (!run) begin
      sck_q <= cpol;
      if (start) begin
        run     <= 1'b1;
        div_cnt <= half_m1;
        tgl_cnt <= '0;
      end
    end else if (div_cnt == '0) begin
      sck_q   <= ~sck_q;
      div_cnt <= half_m1;
      if (tgl_cnt == 4'd15) run <= 1'b0;
      else                  tgl_cnt <= tgl_cnt + 4'd1;
    end else begin
      div_cnt <= div_cnt - 1'b1;
    end
  end

  // R3: no SCK change until the half-period count runs out
  a_r3_half_stable: assert property (@(posedge clk) disable iff (rst)
    (run && div_cnt != '0) |=> $stable(sck_q));

  // R4: an idle generator settles on the polarity level
  a_r4_idle_rest: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> (sck_q == $past(cpol)));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpol,
  input  logic         sck_s,
  input  logic         sdi_s,
  input  logic         ss_clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         sdo_bit,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_data
);
  localparam int CW = $clog2(W);

  logic          sck_prev;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          rx_bit;
  logic          lead, trail;

  always_comb begin
    lead  = (sck_s != sck_prev) && (sck_s != cpol);
    trail = (sck_s != sck_prev) && (sck_s == cpol);
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      sck_prev <= cpol;
      sh       <= '0;
      cnt      <= '0;
      rx_bit   <= 1'b0;
      rx_data  <= '0;
    end else begin
      sck_prev <= sck_s;
      if (ss_clr) begin
        cnt <= '0;
      end else if (load) begin
        sh <= load_data;
      end else if (lead) begin
        rx_bit <= sdi_s;
        if (cnt == CW'(W - 1)) begin
          cnt     <= '0;
          done    <= 1'b1;
          rx_data <= {sh[W-2:0], sdi_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (trail && cnt != '0) begin
        sh <= {sh[W-2:0], rx_bit};
      end
    end
  end

  assign sdo_bit = sh[W-1];
  assign busy    = (cnt != '0);

  // R6: between bytes the shift register only changes by a host load
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> $stable(sh));

  // R9: an active slave-select hold leaves the counter at zero
  a_r9_ss_clears: assert property (@(posedge clk) disable iff (rst)
    ss_clr |=> !busy);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HALF_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [5:0]        ctrl_wdata,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              buf_full,
  output logic              wcol,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              ss_n
);
  ctrl_t       ctrl;
  role_e       role;
  logic        eng_rst;
  logic        is_master, is_slave, ss_used;
  logic        sck_s, sdi_s, ss_s;
  logic        ss_clr, load, start, busy;
  logic        gen_sck, gen_run;
  logic        sh_msb, sh_busy, rx_done;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst)          ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_t'(ctrl_wdata);
  end

  always_comb begin
    role      = decode_role(ctrl.mode);
    eng_rst   = rst || !ctrl.en;
    is_master = (role == ROLE_MASTER);
    is_slave  = (role == ROLE_SLAVE);
    ss_used   = is_slave && !ctrl.mode[0];
    ss_clr    = ss_used && ss_s;
    busy      = gen_run || sh_busy;
    load      = buf_wr && !busy && (is_master || is_slave);
    start     = load && is_master;
  end

  spi_sync #(.W(3), .STAGES(2), .INIT(3'b100)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n, sck_i, sdi}),
    .q   ({ss_s, sck_s, sdi_s})
  );

  spi_clkgen #(.HALF_BASE(HALF_BASE)) clkgen_i (
    .clk     (clk),
    .rst     (eng_rst),
    .start   (start),
    .cpol    (ctrl.cpol),
    .div_sel (ctrl.mode[1:0]),
    .sck_q   (gen_sck),
    .run     (gen_run)
  );

  spi_shifter #(.W(DATA_W)) shifter_i (
    .clk       (clk),
    .rst       (eng_rst),
    .cpol      (ctrl.cpol),
    .sck_s     (sck_s),
    .sdi_s     (sdi_s),
    .ss_clr    (ss_clr),
    .load      (load),
    .load_data (buf_wdata),
    .sdo_bit   (sh_msb),
    .busy      (sh_busy),
    .done      (rx_done),
    .rx_data   (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          buf_q <= '0;
    else if (load)    buf_q <= buf_wdata;
    else if (rx_done) buf_q <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (eng_rst) begin
      sck_o    <= ctrl.cpol;
      sck_oe   <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      buf_full <= 1'b0;
      wcol     <= 1'b0;
    end else begin
      sck_o  <= is_master ? gen_sck : ctrl.cpol;
      sck_oe <= is_master;
      sdo    <= sh_msb;
      sdo_oe <= is_master || (is_slave && !ss_clr);
      if (rx_done)     buf_full <= 1'b1;
      else if (buf_rd) buf_full <= 1'b0;
      if (ctrl_wr)                     wcol <= 1'b0;
      else if (buf_wr && busy)         wcol <= 1'b1;
    end
  end

  assign buf_rdata = buf_q;

  // R1: a disabled port drives nothing on the next cycle
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> (!sck_oe && !sdo_oe && !buf_full));

  // R7: a finished byte raises the full flag
  a_r7_full_after_done: assert property (@(posedge clk) disable iff (eng_rst)
    (rx_done && !ctrl_wr) |=> buf_full);

  // R8: a write during a transfer is flagged
  a_r8_collision: assert property (@(posedge clk) disable iff (eng_rst)
    (buf_wr && busy && !ctrl_wr) |=> wcol);

  // R2: an inactive mode code never enables an output
  a_r2_off_mode: assert property (@(posedge clk) disable iff (eng_rst)
    (role == ROLE_OFF && !ctrl_wr) |=> (!sck_oe && !sdo_oe));
endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic       buf_rd = 1'b0;
  logic [7:0] buf_rdata;
  logic       buf_full, wcol;
  logic       sck_i, sck_o, sck_oe, sdi, sdo, sdo_oe;
  logic       ss_n = 1'b1;
  logic       loop_sck = 1'b1, loop_sdi = 1'b1;
  logic       tb_sck = 1'b0, tb_sdi = 1'b0;

  int n_chk = 0, n_err = 0, tgl = 0, cyc = 0;
  logic sck_last = 1'b0;
  bit   fin = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign sck_i = loop_sck ? sck_o : tb_sck;
  assign sdi   = loop_sdi ? sdo   : tb_sdi;

  spi_port dut_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
    .buf_rdata(buf_rdata), .buf_full(buf_full), .wcol(wcol),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  always @(posedge clk) begin
    if (sck_o !== sck_last) tgl <= tgl + 1;
    sck_last <= sck_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic en, input logic cpol, input logic [3:0] mode);
    ctrl_wdata = {en, cpol, mode};
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  // disable, let the synchronizers settle, then enable with new settings
  task automatic config_port(input logic cpol, input logic [3:0] mode);
    set_ctrl(1'b0, cpol, mode);
    cyc_wait(4);
    set_ctrl(1'b1, cpol, mode);
    cyc_wait(2);
  endtask

  task automatic write_buf(input logic [7:0] b);
    buf_wdata = b;
    buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic read_buf();
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
  endtask

  // bench acting as master toward a slave-mode port
  task automatic slave_xfer(input logic cpol, input logic [7:0] mosi,
                            input int nbits, output logic [7:0] miso);
    miso = '0;
    for (int i = 0; i < nbits; i++) begin
      tb_sdi = mosi[7-i];
      cyc_wait(8);
      miso[7-i] = sdo;
      tb_sck = ~cpol;
      cyc_wait(8);
      tb_sck = cpol;
    end
    cyc_wait(8);
  endtask

  // vector: [19] cpol, [18:17] divider, [16] sdi looped, [15:8] tx byte, [7:0] expected rx
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b1, 8'hA5, 8'hA5},
    {1'b1, 2'd0, 1'b1, 8'h3C, 8'h3C},
    {1'b0, 2'd1, 1'b1, 8'h81, 8'h81},
    {1'b1, 2'd0, 1'b1, 8'h00, 8'h00},
    {1'b0, 2'd0, 1'b1, 8'hFF, 8'hFF},
    {1'b1, 2'd1, 1'b1, 8'h5A, 8'h5A},
    {1'b0, 2'd0, 1'b0, 8'h12, 8'hFF},
    {1'b1, 2'd0, 1'b0, 8'hED, 8'h00}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] miso;
    cyc_wait(3);
    rst = 1'b0;
    cyc_wait(1);
    // reset state
    chk("R1 reset sck_oe", sck_oe, 0);
    chk("R1 reset sdo_oe", sdo_oe, 0);
    chk("R7 reset buf_full", buf_full, 0);
    chk("R8 reset wcol", wcol, 0);
    chk("R4 reset sck level", sck_o, 0);

    // master loopback and constant-SDI vectors
    for (int v = 0; v < NV; v++) begin
      logic       cp;
      logic [1:0] dv;
      cp = VEC[v][19];
      dv = VEC[v][18:17];
      loop_sdi = VEC[v][16];
      tb_sdi   = (VEC[v][7:0] == 8'hFF);
      config_port(cp, {2'b00, dv});
      chk("R4 idle before", sck_o, cp);
      chk("R2 master sck_oe", sck_oe, 1);
      tgl = 0;
      write_buf(VEC[v][15:8]);
      cyc_wait(3);
      chk("R7 not full mid-transfer", buf_full, 0);
      cyc_wait(100 + 200 * dv);
      chk("R3 sixteen sck changes", tgl, 16);
      chk("R4 idle after", sck_o, cp);
      chk("R7 full after byte", buf_full, 1);
      chk("R5 received byte", buf_rdata, VEC[v][7:0]);
      read_buf();
      chk("R7 cleared by read", buf_full, 0);
    end
    loop_sdi = 1'b1;

    // R3 divider period: mode 01 gives 16-cycle halves
    config_port(1'b0, 4'b0001);
    tgl = 0;
    write_buf(8'h77);
    cyc_wait(17);
    chk("R3 no change before half period", tgl, 0);
    cyc_wait(4);
    chk("R3 first change after half period", tgl, 1);
    cyc_wait(300);
    read_buf();

    // R8 write collision
    config_port(1'b0, 4'b0000);
    write_buf(8'h5A);
    cyc_wait(10);
    write_buf(8'h11);
    chk("R8 wcol set", wcol, 1);
    cyc_wait(100);
    chk("R8 original byte kept", buf_rdata, 8'h5A);
    set_ctrl(1'b1, 1'b0, 4'b0000);
    chk("R8 wcol cleared by ctrl write", wcol, 0);
    read_buf();

    // R1 disable mid-transfer
    config_port(1'b1, 4'b0000);
    write_buf(8'hC6);
    cyc_wait(20);
    set_ctrl(1'b0, 1'b1, 4'b0000);
    cyc_wait(1);
    chk("R1 sck_oe off", sck_oe, 0);
    chk("R1 sck at idle", sck_o, 1);
    chk("R1 sdo_oe off", sdo_oe, 0);
    cyc_wait(100);
    chk("R1 no byte after abort", buf_full, 0);

    // R10 master samples returned clock only
    tb_sck = 1'b0;
    config_port(1'b0, 4'b0000);
    loop_sck = 1'b0;
    cyc_wait(4);
    tgl = 0;
    write_buf(8'hA5);
    cyc_wait(100);
    chk("R10 sck still toggled", tgl, 16);
    chk("R10 no byte without return clock", buf_full, 0);

    // R2 inactive mode code
    config_port(1'b0, 4'b1000);
    tgl = 0;
    write_buf(8'h3F);
    cyc_wait(100);
    chk("R2 no sck edges", tgl, 0);
    chk("R2 sck_oe off", sck_oe, 0);
    chk("R2 sdo_oe off", sdo_oe, 0);
    chk("R2 no collision", wcol, 0);

    // slave without SS, polarity 0
    tb_sck = 1'b0;
    config_port(1'b0, 4'b0101);
    loop_sdi = 1'b0;
    write_buf(8'hC3);
    cyc_wait(2);
    chk("R6 slave presents MSb early", sdo, 1);
    chk("R2 slave sdo_oe", sdo_oe, 1);
    chk("R2 slave sck_oe off", sck_oe, 0);
    slave_xfer(1'b0, 8'h96, 8, miso);
    chk("R6 slave sent byte", miso, 8'hC3);
    chk("R5 slave received byte", buf_rdata, 8'h96);
    chk("R7 slave full", buf_full, 1);
    read_buf();

    // slave with SS, polarity 1
    tb_sck = 1'b1;
    ss_n = 1'b1;
    config_port(1'b1, 4'b0100);
    cyc_wait(4);
    chk("R9 sdo_oe off while deselected", sdo_oe, 0);
    slave_xfer(1'b1, 8'h55, 8, miso);
    chk("R9 clocks ignored while deselected", buf_full, 0);
    ss_n = 1'b0;
    cyc_wait(4);
    chk("R9 sdo_oe on when selected", sdo_oe, 1);
    slave_xfer(1'b1, 8'hE0, 3, miso);
    ss_n = 1'b1;
    cyc_wait(6);
    ss_n = 1'b0;
    cyc_wait(4);
    write_buf(8'h81);
    slave_xfer(1'b1, 8'h4E, 8, miso);
    chk("R9 partial byte discarded", buf_rdata, 8'h4E);
    chk("R6 polarity-1 slave sent byte", miso, 8'h81);
    chk("R7 full after SS byte", buf_full, 1);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule